// File: doc/BRIEF.md
# Double-Word Reciprocal Generator

This block turns a W-bit unsigned divisor d into the scaled reciprocal C = ceil(2^(2W)/d), delivered as two W-bit words (high and low). A divider that works by multiplication can keep C and then replace each later division by d with a multiply. The quotient is then the top word of n·C, so no shift and no correction step are needed. The request is a single-cycle `start` strobe with the divisor. The result comes back with a single-cycle `done` strobe.

The ceiling division has a dividend of 2W+1 bits. The block builds it from two 2W-by-W floor divisions that run one after the other on one restoring shift-subtract unit, which retires one quotient bit per clock.
- The first division takes the dividend {1, 0}. Its quotient is the high word floor(2^W/d), and its remainder is r = 2^W mod d.
- The second division takes the dividend {r, d−1}. Its quotient is the low word. This works because ceil(x/d) = floor((x+d−1)/d).

The controller has four states, with these transitions:
- IDLE to DIV_HI on an accepted request that needs computing.
- IDLE to DONE for a special divisor or a repeat of the stored divisor.
- DIV_HI to DIV_LO when the first division finishes.
- DIV_LO to DONE when the second division finishes.
- DONE to IDLE always.

Divisors 0 and 1 need no computation. A zero divisor is reported through a flag, so later users of the reciprocal need no zero test. For d = 1, C = 2^(2W) does not fit in two words, and a second flag reports this. The last divisor that was fully computed is kept with its reciprocal, so a repeated request is answered without running the divider.

Top module: `recip_gen`

## Requirements
- R1: Immediately after reset, `done`, `busy`, `div_zero`, `unity`, `recip_hi` and `recip_lo` are all 0.
- R2: For any divisor d ≥ 2, the result at `done` satisfies {recip_hi, recip_lo} = ceil(2^(2W)/d). Both flags are 0 and recip_hi is at least 1.
- R3: For a divisor that needs computing, `done` is first high after the (2W+3)-th rising edge. The edge that samples `start` counts as the first. `busy` is high from the cycle after that edge up to and including the `done` cycle, and low in the cycle after `done`.
- R4: `done` lasts exactly one cycle. `recip_hi`, `recip_lo`, `div_zero` and `unity` change only in a `done` cycle and hold their values otherwise.
- R5: A divisor of 0 yields `div_zero`=1, `unity`=0 and both result words 0. `done` follows after the first edge.
- R6: A divisor of 1 yields `unity`=1, `div_zero`=0 and both result words 0. `done` follows after the first edge.
- R7: A request whose divisor equals the last fully computed divisor returns the same reciprocal with `done` after the first edge. Requests for 0 or 1 do not replace the stored divisor. After reset, nothing is stored.
- R8: `start` is ignored while `busy` is high. The result still belongs to the accepted divisor, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled only when idle |
| divisor | input | W | Divisor d, sampled with `start` |
| busy | output | 1 | Request in progress (any state other than IDLE) |
| done | output | 1 | One-cycle result strobe |
| recip_hi | output | W | High word of C |
| recip_lo | output | W | Low word of C |
| div_zero | output | 1 | Last request had d = 0 |
| unity | output | 1 | Last request had d = 1 |

## Verification
The bound checker watches the handshake and the output registers on every cycle:
- `done` is a single-cycle pulse.
- The results and flags hold between pulses.
- `busy` drops only after `done`, and rises after an accepted request.
- The two flags are never high together.
- A flagged result has both words zero.
- A computed high word is never zero.

The bench scenarios are what show the values themselves. It compares each result against a wide ceiling division for directed and random divisors. It measures the exact latency of computed and repeated requests. It models the stored-divisor behaviour across special requests, and it shows that a strobe raised mid-computation leaves the result untouched.

// File: rtl/recip_pkg.sv
package recip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIV_HI = 2'd1,
        ST_DIV_LO = 2'd2,
        ST_DONE   = 2'd3
    } recip_state_t;

endpackage

// File: rtl/recip_divider.sv
// Restoring shift-subtract divider: 2W-bit dividend {hi, lo} by W-bit divisor.
// Precondition: hi < divisor, so quotient fits W bits. One quotient bit per cycle.
module recip_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvsr,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  acc_q;
    logic [W-1:0]  dvsr_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          fin_q;

    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          ge;
    logic [W-1:0]  next_rem;
    logic [W-1:0]  next_acc;

    always_comb begin
        shifted  = {rem_q, acc_q[W-1]};
        diff     = shifted - {1'b0, dvsr_q};
        ge       = shifted >= {1'b0, dvsr_q};
        next_rem = ge ? diff[W-1:0] : shifted[W-1:0];
        next_acc = {acc_q[W-2:0], ge};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            acc_q  <= '0;
            dvsr_q <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (ld) begin
                rem_q  <= dvd_hi;
                acc_q  <= dvd_lo;
                dvsr_q <= dvsr;
                cnt_q  <= CW'(W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q <= next_rem;
                acc_q <= next_acc;
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin = fin_q;
    assign quo = acc_q;
    assign rem = rem_q;

endmodule

// File: rtl/recip_cache.sv
// Single-entry store of the last fully computed divisor and its reciprocal.
module recip_cache #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_key,
    input  logic [W-1:0] wr_hi,
    input  logic [W-1:0] wr_lo,
    input  logic [W-1:0] look_key,
    output logic         hit,
    output logic [W-1:0] rd_hi,
    output logic [W-1:0] rd_lo
);
    logic         valid_q;
    logic [W-1:0] key_q;
    logic [W-1:0] hi_q;
    logic [W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            key_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            key_q   <= wr_key;
            hi_q    <= wr_hi;
            lo_q    <= wr_lo;
        end
    end

    assign hit   = valid_q && (key_q == look_key);
    assign rd_hi = hi_q;
    assign rd_lo = lo_q;

endmodule

// File: rtl/recip_gen.sv
module recip_gen
    import recip_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] recip_hi,
    output logic [W-1:0] recip_lo,
    output logic         div_zero,
    output logic         unity
);
    recip_state_t state_q, state_d;

    logic [W-1:0] d_q;
    logic [W-1:0] ch_q;
    logic         is_zero, is_one, special;
    logic         accept;
    logic         hit;
    logic [W-1:0] rd_hi, rd_lo;

    logic         div_ld;
    logic [W-1:0] div_hi_in, div_lo_in, div_dvsr_in;
    logic         div_fin;
    logic [W-1:0] div_quo, div_rem;
    logic         cache_wr;

    assign is_zero = (divisor == '0);
    assign is_one  = (divisor == W'(1));
    assign special = is_zero || is_one;
    assign accept  = (state_q == ST_IDLE) && start;

    // first division: {1, 0} / d ; second: {r, d-1} / d
    always_comb begin
        div_ld      = 1'b0;
        div_hi_in   = W'(1);
        div_lo_in   = '0;
        div_dvsr_in = divisor;
        if (state_q == ST_IDLE) begin
            div_ld = accept && !special && !hit;
        end else begin
            div_ld      = (state_q == ST_DIV_HI) && div_fin;
            div_hi_in   = div_rem;
            div_lo_in   = d_q - W'(1);
            div_dvsr_in = d_q;
        end
    end

    recip_divider #(.W(W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (div_ld),
        .dvd_hi (div_hi_in),
        .dvd_lo (div_lo_in),
        .dvsr   (div_dvsr_in),
        .fin    (div_fin),
        .quo    (div_quo),
        .rem    (div_rem)
    );

    assign cache_wr = (state_q == ST_DIV_LO) && div_fin;

    recip_cache #(.W(W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cache_wr),
        .wr_key   (d_q),
        .wr_hi    (ch_q),
        .wr_lo    (div_quo),
        .look_key (divisor),
        .hit      (hit),
        .rd_hi    (rd_hi),
        .rd_lo    (rd_lo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (special || hit) state_d = ST_DONE;
                    else                state_d = ST_DIV_HI;
                end
            end
            ST_DIV_HI: if (div_fin) state_d = ST_DIV_LO;
            ST_DIV_LO: if (div_fin) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q      <= '0;
            ch_q     <= '0;
            recip_hi <= '0;
            recip_lo <= '0;
            div_zero <= 1'b0;
            unity    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        d_q <= divisor;
                        if (special) begin
                            recip_hi <= '0;
                            recip_lo <= '0;
                            div_zero <= is_zero;
                            unity    <= is_one;
                        end else if (hit) begin
                            recip_hi <= rd_hi;
                            recip_lo <= rd_lo;
                            div_zero <= 1'b0;
                            unity    <= 1'b0;
                        end
                    end
                end
                ST_DIV_HI: begin
                    if (div_fin) ch_q <= div_quo;
                end
                ST_DIV_LO: begin
                    if (div_fin) begin
                        recip_hi <= ch_q;
                        recip_lo <= div_quo;
                        div_zero <= 1'b0;
                        unity    <= 1'b0;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/recip_gen_chk.sv
module recip_gen_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] recip_hi,
    input logic [W-1:0] recip_lo,
    input logic         div_zero,
    input logic         unity
);
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(recip_hi) && $stable(recip_lo) && $stable(div_zero) && $stable(unity)));

    assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_release_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_accept_raises_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(div_zero && unity));

    assert_special_zero_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_zero || unity) |-> (recip_hi == '0 && recip_lo == '0));

    assert_hi_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !unity) |-> (recip_hi != '0));

endmodule

bind recip_gen recip_gen_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .recip_hi (recip_hi),
    .recip_lo (recip_lo),
    .div_zero (div_zero),
    .unity    (unity)
);

// File: tb/recip_gen_test.sv
`timescale 1ns/1ps
module recip_gen_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero, unity;
    logic [W-1:0] recip_hi, recip_lo;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          st_valid = 1'b0;
    logic [W-1:0] st_key = '0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    recip_gen #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
        .busy(busy), .done(done), .recip_hi(recip_hi), .recip_lo(recip_lo),
        .div_zero(div_zero), .unity(unity)
    );

    function automatic logic [2*W-1:0] ref_recip(input logic [W-1:0] d);
        logic [2*W+1:0] num;
        logic [2*W+1:0] q;
        num = ((2*W+2)'(1) << (2*W)) + (2*W+2)'(d) - (2*W+2)'(1);
        q   = num / (2*W+2)'(d);
        return q[2*W-1:0];
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one request and check result, latency, flags
    task automatic run(input logic [W-1:0] d);
        int lat;
        int exp_lat;
        logic [2*W-1:0] exp_c;
        bit fresh;
        fresh   = (d > 1) && !(st_valid && st_key == d);
        exp_lat = fresh ? (2*W+3) : 1;
        exp_c   = (d > 1) ? ref_recip(d) : '0;
        @(negedge clk);
        divisor = d;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        lat     = 1;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        if (d == 0) begin
            chk(div_zero == 1'b1 && unity == 1'b0, "R5 flags", {div_zero, unity}, 2'b10);
            chk({recip_hi, recip_lo} == '0, "R5 words", {recip_hi, recip_lo}, '0);
            chk(lat == 1, "R5 latency", lat, 1);
        end else if (d == 1) begin
            chk(unity == 1'b1 && div_zero == 1'b0, "R6 flags", {div_zero, unity}, 2'b01);
            chk({recip_hi, recip_lo} == '0, "R6 words", {recip_hi, recip_lo}, '0);
            chk(lat == 1, "R6 latency", lat, 1);
        end else begin
            chk({recip_hi, recip_lo} == exp_c, "R2 value", {recip_hi, recip_lo}, exp_c);
            chk(!div_zero && !unity, "R2 flags", {div_zero, unity}, 0);
            if (fresh) chk(lat == exp_lat, "R3 latency", lat, exp_lat);
            else       chk(lat == exp_lat, "R7 hit latency", lat, exp_lat);
            st_valid = 1'b1;
            st_key   = d;
        end
        @(negedge clk);
        chk(!done && !busy, "R4 single pulse / R3 release", {done, busy}, 0);
    endtask

    initial begin
        int unsigned seed;
        logic [W-1:0] hold_hi;
        logic [W-1:0] hold_lo;
        logic [2*W-1:0] exp8;
        int extra;
        seed = $urandom(32'd97531);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done && !busy && !div_zero && !unity && recip_hi == '0 && recip_lo == '0,
            "R1 reset", {done, busy, div_zero, unity, recip_hi}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy, "R1 after release", {done, busy}, 0);

        // R5, R6 special divisors
        run('0);
        run(W'(1));
        // R2 / R3 directed
        run(W'(2));
        run(W'(3));
        run(W'(7));
        run(W'(10));
        for (int k = 2; k < W; k += 7) run(W'(1) << k);
        run(W'(1) << (W-1));
        run({W{1'b1}});
        run({W{1'b1}} - W'(1));
        // R7 repeat hits, special requests do not replace stored entry
        run(W'(10));
        run('0);
        run(W'(1));
        run(W'(10));

        // R4 hold between pulses
        hold_hi = recip_hi;
        hold_lo = recip_lo;
        repeat (5) @(negedge clk);
        chk(recip_hi == hold_hi && recip_lo == hold_lo && !done, "R4 hold",
            {recip_hi, recip_lo}, {hold_hi, hold_lo});

        // R8 start ignored while busy
        @(negedge clk);
        divisor = W'(12345);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        repeat (10) @(negedge clk);
        divisor = W'(3);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        divisor = '0;
        while (!done) @(negedge clk);
        exp8 = ref_recip(W'(12345));
        chk({recip_hi, recip_lo} == exp8, "R8 result of accepted divisor",
            {recip_hi, recip_lo}, exp8);
        st_valid = 1'b1;
        st_key   = W'(12345);
        extra = 0;
        repeat (8) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        chk(extra == 0, "R8 no extra done", extra, 0);

        // random divisors, mixed small/large, with repeats
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] d;
            int unsigned sel;
            sel = $urandom % 8;
            if (sel == 0)      d = W'($urandom % 16);
            else if (sel == 1) d = st_key;
            else if (sel == 2) d = W'(1) << ($urandom % W);
            else               d = W'($urandom);
            run(d);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            summary();
            $finish;
        end
    end

endmodule